// File: doc/BRIEF.md
# Logic Gate Ring Sequencer

This block is the timing backbone of a processor's control section. It holds a one-hot ring of gate signals and moves one position each time the system clock's phase strobe asks it to advance. The main branch runs through eleven gates, A to K. A second, shorter branch of six gates, R to W, is entered only to serve an overlapped I/O transfer. That transfer takes a whole pass of the ring from the instruction stream, in the manner of cycle stealing.

The instruction logic raises a last-gate indication when the current operation needs no further gates, and the ring then goes back to A. If an overlapped I/O request is waiting at that moment, the ring goes to R instead. It walks R to W and then rejoins at A. A cycle-disable input freezes the ring where it stands. A pending non-overlapped I/O request for the first channel overrides that freeze. An active-low program reset puts the ring at A. The reset is sampled on the clock edge.

Top module: `gate_ring_seq`

## Requirements
- R1: While `prog_rst_n` is low at a rising clock edge, the next state is gate A: `norm_gate` = bit 0 only and `ovl_gate` = 0. This takes priority over every other input.
- R2: At all times after the first reset edge, exactly one bit of the combined vector {`ovl_gate`, `norm_gate`} is 1.
- R3: When `adv` is low, the gate outputs do not change.
- R4: On an effective advance in normal gate i (bit i of `norm_gate`), with i below K and `last_gate` low, the ring moves to gate i+1. An advance is effective when `adv` is high and the ring is not frozen.
- R5: On an effective advance in any normal gate, with `last_gate` high and `io_ovl_req` low, the ring moves to gate A.
- R6: In gate K (bit 10 of `norm_gate`), an effective advance with `last_gate` low leaves the ring at K.
- R7: When `freeze` is high and `io_now_req` is low, an advance strobe does not change the gate outputs.
- R8: When `freeze` and `io_now_req` are both high, an advance strobe moves the ring as in R4 to R6 and R9.
- R9: On an effective advance in any normal gate, with `last_gate` high and `io_ovl_req` high, the ring moves to gate R (bit 0 of `ovl_gate`).
- R10: In the overlapped branch, each effective advance moves from bit j of `ovl_gate` to bit j+1, whatever `last_gate` is. From W (bit 5) the ring moves to gate A.
- R11: If `last_gate` is low, `io_ovl_req` has no effect on where a normal gate steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| prog_rst_n | input | 1 | Program reset, active low, synchronous |
| adv | input | 1 | Phase strobe; the ring moves only on cycles where it is high |
| last_gate | input | 1 | Instruction logic needs no more gates this pass |
| freeze | input | 1 | Cycle disable; holds the ring in place |
| io_now_req | input | 1 | Non-overlapped I/O request, first channel; overrides freeze |
| io_ovl_req | input | 1 | Overlapped I/O request waiting for a stolen cycle |
| norm_gate | output | 11 | One-hot gates A..K (bit 0 = A) |
| ovl_gate | output | 6 | One-hot gates R..W (bit 0 = R) |

## Verification
Directed runs walk the ring from A all the way to K without a last-gate signal, which separates plain stepping from the hold at K. Short passes that end with last-gate, with and without a waiting overlapped request, separate a return to A from entry to R. Freeze is applied once alone and once together with a non-overlapped request, which tells the hold apart from the override. In the overlapped branch, last-gate is held high while the ring steps, to show that it is ignored there. A long run of mixed random strobes, freezes, requests and occasional resets is then compared against a behavioural model on every clock.

// File: rtl/gr_pkg.sv
package gr_pkg;
  localparam int unsigned GR_NORM_GATES = 11;
  localparam int unsigned GR_OVL_GATES  = 6;

  // Return decision inputs bundled for the next-state logic
  typedef struct packed {
    logic done;         // instruction logic finished this pass
    logic ovl_pending;  // overlapped transfer waiting
  } gr_ret_t;
endpackage

// File: rtl/gr_enable.sv
module gr_enable (
  input  logic adv,
  input  logic freeze,
  input  logic io_now_req,
  output logic go
);
  // Freeze blocks the strobe unless a non-overlapped transfer needs the ring
  always_comb go = adv & (~freeze | io_now_req);
endmodule

// File: rtl/gr_step.sv
module gr_step
  import gr_pkg::*;
#(
  parameter int unsigned NORM_N = GR_NORM_GATES,
  parameter int unsigned OVL_N  = GR_OVL_GATES
) (
  input  logic [NORM_N-1:0] cur_n,
  input  logic [OVL_N-1:0]  cur_o,
  input  gr_ret_t           ret,
  output logic [NORM_N-1:0] nxt_n,
  output logic [OVL_N-1:0]  nxt_o
);
  logic in_norm, leave_norm, to_steal, to_head;

  always_comb begin
    in_norm    = |cur_n;
    leave_norm = in_norm & ret.done;
    to_steal   = leave_norm & ret.ovl_pending;
    to_head    = (leave_norm & ~ret.ovl_pending) | cur_o[OVL_N-1];
  end

  // Normal branch: head, shift chain, and a self-holding tail
  always_comb nxt_n[0] = to_head;

  for (genvar i = 1; i < NORM_N; i++) begin : g_norm
    if (i == NORM_N - 1) begin : g_tail
      always_comb nxt_n[i] = (cur_n[i-1] | cur_n[i]) & ~ret.done;
    end else begin : g_mid
      always_comb nxt_n[i] = cur_n[i-1] & ~ret.done;
    end
  end

  // Overlapped branch: entered from the return point, plain shift after
  always_comb nxt_o[0] = to_steal;

  for (genvar j = 1; j < OVL_N; j++) begin : g_ovl
    always_comb nxt_o[j] = cur_o[j-1];
  end
endmodule

// File: rtl/gr_reg.sv
module gr_reg #(
  parameter int unsigned W = 17,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST_VAL;
    else if (en) q <= d;
  end

  // R3 / R7: with no enable the register keeps its value
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/gate_ring_seq.sv
module gate_ring_seq
  import gr_pkg::*;
#(
  parameter int unsigned NORM_N = GR_NORM_GATES,
  parameter int unsigned OVL_N  = GR_OVL_GATES
) (
  input  logic              clk,
  input  logic              prog_rst_n,
  input  logic              adv,
  input  logic              last_gate,
  input  logic              freeze,
  input  logic              io_now_req,
  input  logic              io_ovl_req,
  output logic [NORM_N-1:0] norm_gate,
  output logic [OVL_N-1:0]  ovl_gate
);
  localparam int unsigned TOT = NORM_N + OVL_N;
  localparam logic [TOT-1:0] HEAD = TOT'(1);

  logic            go;
  gr_ret_t         ret;
  logic [TOT-1:0]  ring_q, ring_d;
  logic [NORM_N-1:0] nxt_n;
  logic [OVL_N-1:0]  nxt_o;

  gr_enable u_en (
    .adv        (adv),
    .freeze     (freeze),
    .io_now_req (io_now_req),
    .go         (go)
  );

  always_comb begin
    ret.done        = last_gate;
    ret.ovl_pending = io_ovl_req;
  end

  gr_step #(.NORM_N(NORM_N), .OVL_N(OVL_N)) u_step (
    .cur_n (ring_q[NORM_N-1:0]),
    .cur_o (ring_q[TOT-1:NORM_N]),
    .ret   (ret),
    .nxt_n (nxt_n),
    .nxt_o (nxt_o)
  );

  always_comb ring_d = {nxt_o, nxt_n};

  gr_reg #(.W(TOT), .RST_VAL(HEAD)) u_ring (
    .clk   (clk),
    .rst_n (prog_rst_n),
    .en    (go),
    .d     (ring_d),
    .q     (ring_q)
  );

  always_comb begin
    norm_gate = ring_q[NORM_N-1:0];
    ovl_gate  = ring_q[TOT-1:NORM_N];
  end

  // R2: a single gate is live
  a_r2_one_gate: assert property (@(posedge clk) disable iff (!prog_rst_n)
    $countones({ovl_gate, norm_gate}) == 1);

  // R7: freeze without a non-overlapped request holds the ring
  a_r7_freeze_hold: assert property (@(posedge clk) disable iff (!prog_rst_n)
    (freeze && !io_now_req) |=> $stable({ovl_gate, norm_gate}));

  // R8: the override lets gate A move on to B
  a_r8_override_moves: assert property (@(posedge clk) disable iff (!prog_rst_n)
    (adv && freeze && io_now_req && norm_gate[0] && !last_gate) |=> norm_gate[1]);

  // R9: a waiting overlapped request diverts the return into the stolen branch
  a_r9_enter_ovl: assert property (@(posedge clk) disable iff (!prog_rst_n)
    (go && (|norm_gate) && last_gate && io_ovl_req) |=> ovl_gate[0]);

  // R10: the last stolen gate rejoins at A
  a_r10_w_returns: assert property (@(posedge clk) disable iff (!prog_rst_n)
    (go && ovl_gate[OVL_N-1]) |=> norm_gate[0]);
endmodule

// File: tb/sim_gate_ring_seq.sv
module sim_gate_ring_seq;
  localparam int NN = 11;
  localparam int NO = 6;
  localparam int NT = NN + NO;

  logic clk = 1'b0;
  logic rst_n = 1'b0, adv = 1'b0, last = 1'b0, frz = 1'b0, nov = 1'b0, ovr = 1'b0;
  logic [NN-1:0] ng;
  logic [NO-1:0] og;
  int tests = 0, fails = 0;
  int midx = 0;  // model: 0..NN-1 normal gates, NN..NT-1 stolen gates

  always #5 clk = ~clk;

  gate_ring_seq u0 (
    .clk (clk), .prog_rst_n (rst_n), .adv (adv), .last_gate (last),
    .freeze (frz), .io_now_req (nov), .io_ovl_req (ovr),
    .norm_gate (ng), .ovl_gate (og)
  );

  task automatic tick(input string tag);
    logic [NT-1:0] e, a;
    @(posedge clk);
    if (!rst_n) midx = 0;
    else if (adv && (!frz || nov)) begin
      if (midx < NN) begin
        if (last) midx = ovr ? NN : 0;
        else if (midx < NN - 1) midx = midx + 1;
      end else begin
        midx = (midx == NT - 1) ? 0 : midx + 1;
      end
    end
    @(negedge clk);
    e = '0;
    e[midx] = 1'b1;
    a = {og, ng};
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: gates act=%b exp=%b", tag, a, e);
    end
    tests++;
    if ($countones(a) != 1) begin
      fails++;
      $display("FAIL R2: active gate count act=%0d exp=1", $countones(a));
    end
  endtask

  initial begin
    repeat (3) tick("R1");                 // reset to A
    rst_n = 1'b1;
    repeat (3) tick("R3");                 // no strobe, no motion
    adv = 1'b1;
    repeat (10) tick("R4");                // A through K
    repeat (3) tick("R6");                 // hold at K
    last = 1'b1; tick("R5");               // back to A
    last = 1'b0;
    repeat (3) tick("R4");                 // to gate D
    frz = 1'b1; repeat (3) tick("R7");     // frozen
    nov = 1'b1; repeat (2) tick("R8");     // override
    frz = 1'b0; nov = 1'b0;
    ovr = 1'b1; repeat (2) tick("R11");    // request ignored mid-pass
    last = 1'b1; tick("R9");               // divert into R
    ovr = 1'b0;
    repeat (5) tick("R10");                // R..W, last ignored
    tick("R10");                           // W back to A
    ovr = 1'b1; tick("R9");
    last = 1'b0; ovr = 1'b0;
    repeat (2) tick("R10");
    rst_n = 1'b0; tick("R1");              // reset from stolen branch
    rst_n = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      adv   = ($urandom % 4) != 0;
      last  = ($urandom % 6) == 0;
      frz   = ($urandom % 5) == 0;
      nov   = ($urandom % 3) == 0;
      ovr   = ($urandom % 3) == 0;
      rst_n = ($urandom % 200) != 0;
      tick("R2");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule